// File: doc/BRIEF.md
# Processor Privilege Mode Controller

This block holds the operating-mode state of a 32-bit processor core. A small status word carries a 3-bit mode code and two interrupt-mask bits. Seven modes exist: one unprivileged user mode and six privileged ones. Five of the privileged modes are exception modes, entered by hardware when the matching event is raised. The sixth is a privileged system mode that runs on the user register bank.

Software may also change the status word through a write port, but only from a privileged mode. On every exception entry the block saves the outgoing status word in a saved-status slot for the mode being entered. A return strobe copies that slot back. The outputs give the pipeline the current mode, a privilege flag and the register-bank index to use.

Top module: `pmc_mode_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the status becomes mode supervisor (code 3) with both masks set (`fast_mask`=1, `norm_mask`=1). Reset takes precedence over every other input.
- R2: Mode codes are user=0, fast-interrupt=1, normal-interrupt=2, supervisor=3, abort=4, undefined=5 and system=6. `privileged` is 0 only in user mode.
- R3: `bank_sel` is 0 in both user and system modes. In the exception modes it equals the mode code (1 to 5).
- R4: Events arriving in the same cycle are served in this order: reset, abort, unmasked fast interrupt, unmasked normal interrupt, undefined instruction, software interrupt. Software interrupt enters supervisor.
- R5: Entry to the fast-interrupt mode sets both masks. Entry to any other exception mode sets `norm_mask` and leaves `fast_mask` unchanged.
- R6: A fast interrupt while `fast_mask`=1, or a normal interrupt while `norm_mask`=1, changes neither the mode nor the masks.
- R7: A status write (`wr_en`) issued in user mode is ignored.
- R8: A status write whose mode field is code 7 is ignored.
- R9: A status write from a privileged mode loads the whole status word in the next cycle. The field layout is `wr_status[2:0]`=mode, bit 3=`norm_mask`, bit 4=`fast_mask`.
- R10: On exception entry, the previous status word is saved in the slot of the mode being entered. In an exception mode, `eret` restores the status word from the current mode's slot, so nested entries unwind in order.
- R11: `eret` has no effect in user or system mode.
- R12: An exception taken in the same cycle as a status write or `eret` wins, and the write or return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also the reset event |
| fiq_req | input | 1 | Fast (high-priority) interrupt request, level |
| irq_req | input | 1 | Normal (low-priority) interrupt request, level |
| swi_req | input | 1 | Software-interrupt instruction executed |
| abort_req | input | 1 | Faulting memory access |
| undef_req | input | 1 | Undefined instruction executed |
| wr_en | input | 1 | Status write strobe |
| wr_status | input | 5 | Status value to write: {fast_mask, norm_mask, mode[2:0]} |
| eret | input | 1 | Exception-return strobe |
| cur_mode | output | 3 | Current mode code |
| fast_mask | output | 1 | Fast interrupts masked |
| norm_mask | output | 1 | Normal interrupts masked |
| privileged | output | 1 | Current mode is privileged |
| bank_sel | output | 3 | Register-bank index |

## Verification
The bench targets coincident events and checks that the highest-ranked one wins. A design with a mis-ordered priority chain would enter, for example, the fast-interrupt mode while an abort is pending, or the software-interrupt mode ahead of an undefined instruction. It also nests a fast interrupt inside a normal interrupt and unwinds both returns. A design with a single shared save slot would return to the wrong mode or with the wrong masks. Writes from user mode, writes of the unused code, and returns from system mode are all checked to leave the state untouched. A design that skipped any of these guards would let user code raise its own privilege or jump to a garbage mode.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    localparam int MODE_W   = 3;
    localparam int STATUS_W = MODE_W + 2;
    localparam int EXC_LO   = 1;
    localparam int EXC_HI   = 5;

    typedef enum logic [MODE_W-1:0] {
        MODE_USER   = 3'd0,
        MODE_FAST   = 3'd1,
        MODE_NORM   = 3'd2,
        MODE_SUPER  = 3'd3,
        MODE_ABORT  = 3'd4,
        MODE_UNDEF  = 3'd5,
        MODE_SYSTEM = 3'd6
    } mode_e;

    typedef struct packed {
        logic  fast_mask;
        logic  norm_mask;
        mode_e mode;
    } status_t;

    function automatic logic mode_valid(logic [MODE_W-1:0] m);
        return m != 3'd7;
    endfunction

    function automatic logic is_exc(mode_e m);
        return (m != MODE_USER) && (m != MODE_SYSTEM);
    endfunction

    function automatic logic [MODE_W-1:0] bank_of(mode_e m);
        return (m == MODE_SYSTEM) ? 3'd0 : m;
    endfunction
endpackage

// File: rtl/pmc_event_arb.sv
module pmc_event_arb
    import pmc_pkg::*;
(
    input  logic    fiq_req,
    input  logic    irq_req,
    input  logic    swi_req,
    input  logic    abort_req,
    input  logic    undef_req,
    input  status_t st,
    output logic    take,
    output mode_e   target
);
    always_comb begin
        take   = 1'b1;
        target = MODE_USER;
        if (abort_req)                     target = MODE_ABORT;
        else if (fiq_req && !st.fast_mask) target = MODE_FAST;
        else if (irq_req && !st.norm_mask) target = MODE_NORM;
        else if (undef_req)                target = MODE_UNDEF;
        else if (swi_req)                  target = MODE_SUPER;
        else                               take   = 1'b0;
    end
endmodule

// File: rtl/pmc_saved_bank.sv
module pmc_saved_bank
    import pmc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    save_en,
    input  mode_e   save_mode,
    input  status_t save_val,
    input  mode_e   rd_mode,
    output status_t rd_val
);
    status_t slot_q [EXC_LO:EXC_HI];

    for (genvar i = EXC_LO; i <= EXC_HI; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot_q[i] <= '0;
            else if (save_en && save_mode == mode_e'(i))
                slot_q[i] <= save_val;
        end
    end

    always_comb begin
        rd_val = '0;
        for (int i = EXC_LO; i <= EXC_HI; i++)
            if (rd_mode == mode_e'(i)) rd_val = slot_q[i];
    end
endmodule

// File: rtl/pmc_mode_ctrl.sv
module pmc_mode_ctrl
    import pmc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                fiq_req,
    input  logic                irq_req,
    input  logic                swi_req,
    input  logic                abort_req,
    input  logic                undef_req,
    input  logic                wr_en,
    input  logic [STATUS_W-1:0] wr_status,
    input  logic                eret,
    output logic [MODE_W-1:0]   cur_mode,
    output logic                fast_mask,
    output logic                norm_mask,
    output logic                privileged,
    output logic [MODE_W-1:0]   bank_sel
);
    status_t st_q;
    status_t saved_rd;
    status_t wr_val;
    logic    take;
    mode_e   target;

    assign wr_val = status_t'(wr_status);

    pmc_event_arb u_arb (
        .fiq_req(fiq_req), .irq_req(irq_req), .swi_req(swi_req),
        .abort_req(abort_req), .undef_req(undef_req),
        .st(st_q), .take(take), .target(target)
    );

    pmc_saved_bank u_bank (
        .clk(clk), .rst(rst), .save_en(take), .save_mode(target),
        .save_val(st_q), .rd_mode(st_q.mode), .rd_val(saved_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.fast_mask <= 1'b1;
            st_q.norm_mask <= 1'b1;
            st_q.mode      <= MODE_SUPER;
        end else if (take) begin
            st_q.mode      <= target;
            st_q.norm_mask <= 1'b1;
            if (target == MODE_FAST) st_q.fast_mask <= 1'b1;
        end else if (eret && is_exc(st_q.mode)) begin
            st_q <= saved_rd;
        end else if (wr_en && st_q.mode != MODE_USER && mode_valid(wr_status[MODE_W-1:0])) begin
            st_q <= wr_val;
        end
    end

    assign cur_mode   = st_q.mode;
    assign fast_mask  = st_q.fast_mask;
    assign norm_mask  = st_q.norm_mask;
    assign privileged = st_q.mode != MODE_USER;
    assign bank_sel   = bank_of(st_q.mode);
endmodule

// File: rtl/pmc_mode_checker.sv
module pmc_mode_checker
    import pmc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              fiq_req,
    input logic              irq_req,
    input logic              swi_req,
    input logic              abort_req,
    input logic              undef_req,
    input logic              wr_en,
    input logic              eret,
    input logic [MODE_W-1:0] cur_mode,
    input logic              fast_mask,
    input logic              norm_mask
);
    logic quiet;
    assign quiet = !abort_req && !swi_req && !undef_req &&
                   (!fiq_req || fast_mask) && (!irq_req || norm_mask);

    assert_abort_first_R4: assert property (@(posedge clk) disable iff (rst)
        abort_req |=> (cur_mode == 3'd4 && norm_mask));

    assert_fast_masks_R5: assert property (@(posedge clk) disable iff (rst)
        (fiq_req && !fast_mask && !abort_req) |=> (cur_mode == 3'd1 && fast_mask && norm_mask));

    assert_masked_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (quiet && !wr_en && !eret) |=> ($stable(cur_mode) && $stable(fast_mask) && $stable(norm_mask)));

    assert_user_write_R7: assert property (@(posedge clk) disable iff (rst)
        (quiet && cur_mode == 3'd0 && wr_en) |=> (cur_mode == 3'd0));

    assert_sys_eret_R11: assert property (@(posedge clk) disable iff (rst)
        (quiet && !wr_en && cur_mode == 3'd6 && eret) |=> (cur_mode == 3'd6));
endmodule

bind pmc_mode_ctrl pmc_mode_checker u_chk (
    .clk(clk), .rst(rst), .fiq_req(fiq_req), .irq_req(irq_req),
    .swi_req(swi_req), .abort_req(abort_req), .undef_req(undef_req),
    .wr_en(wr_en), .eret(eret), .cur_mode(cur_mode),
    .fast_mask(fast_mask), .norm_mask(norm_mask)
);

// File: tb/tb_pmc_mode_ctrl.sv
module tb_pmc_mode_ctrl;
    logic       clk = 1'b0;
    logic       rst, fiq_req, irq_req, swi_req, abort_req, undef_req, wr_en, eret;
    logic [4:0] wr_status;
    logic [2:0] cur_mode, bank_sel;
    logic       fast_mask, norm_mask, privileged;
    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    pmc_mode_ctrl dut (
        .clk(clk), .rst(rst), .fiq_req(fiq_req), .irq_req(irq_req),
        .swi_req(swi_req), .abort_req(abort_req), .undef_req(undef_req),
        .wr_en(wr_en), .wr_status(wr_status), .eret(eret),
        .cur_mode(cur_mode), .fast_mask(fast_mask), .norm_mask(norm_mask),
        .privileged(privileged), .bank_sel(bank_sel)
    );

    task automatic idle();
        rst = 0; fiq_req = 0; irq_req = 0; swi_req = 0; abort_req = 0;
        undef_req = 0; wr_en = 0; eret = 0; wr_status = '0;
    endtask

    task automatic step();
        @(posedge clk); @(negedge clk);
        idle();
    endtask

    task automatic expect_state(string req, logic [2:0] m, logic fm, logic nm);
        logic [7:0] act, exp;
        act = {fast_mask, norm_mask, privileged, bank_sel, cur_mode[1:0]};
        exp = {fm, nm, (m != 3'd0), (m == 3'd6 ? 3'd0 : m), m[1:0]};
        checks++;
        if (act !== exp || cur_mode !== m) begin
            fails++;
            $display("FAIL %s: mode=%0d fm=%0b nm=%0b priv=%0b bank=%0d expected mode=%0d fm=%0b nm=%0b priv=%0b bank=%0d",
                     req, cur_mode, fast_mask, norm_mask, privileged, bank_sel,
                     m, fm, nm, exp[5], exp[4:2]);
        end
    endtask

    task automatic do_reset();
        idle(); rst = 1; step();
    endtask

    task automatic write(logic [4:0] v);
        wr_en = 1; wr_status = v; step();
    endtask

    task automatic t_reset();
        do_reset();
        expect_state("R1", 3'd3, 1, 1);
        abort_req = 1; fiq_req = 1; rst = 1; step();
        expect_state("R1 reset beats abort (R4)", 3'd3, 1, 1);
    endtask

    task automatic t_writes();
        do_reset();
        write({1'b0, 1'b0, 3'd6});
        expect_state("R9 write system, R3 shared bank", 3'd6, 0, 0);
        write({1'b1, 1'b1, 3'd7});
        expect_state("R8 unused code", 3'd6, 0, 0);
        write({1'b0, 1'b1, 3'd0});
        expect_state("R2 user unprivileged", 3'd0, 0, 1);
        write({1'b1, 1'b1, 3'd3});
        expect_state("R7 user write ignored", 3'd0, 0, 1);
    endtask

    task automatic t_masked();
        do_reset();
        write({1'b1, 1'b1, 3'd0});
        fiq_req = 1; irq_req = 1; step();
        expect_state("R6 both masked", 3'd0, 1, 1);
        do_reset();
        write({1'b0, 1'b1, 3'd0});
        irq_req = 1; step();
        expect_state("R6 normal masked", 3'd0, 0, 1);
        fiq_req = 1; irq_req = 1; step();
        expect_state("R5 fast entry", 3'd1, 1, 1);
    endtask

    task automatic t_entries();
        do_reset();
        write({1'b0, 1'b0, 3'd0});
        fiq_req = 1; step();
        expect_state("R5 fast masks both", 3'd1, 1, 1);
        eret = 1; step();
        expect_state("R10 return from fast", 3'd0, 0, 0);
        irq_req = 1; step();
        expect_state("R5 normal keeps fast mask", 3'd2, 0, 1);
        eret = 1; step();
        expect_state("R10 return from normal", 3'd0, 0, 0);
    endtask

    task automatic t_priority();
        do_reset();
        write({1'b0, 1'b0, 3'd0});
        abort_req = 1; fiq_req = 1; irq_req = 1; undef_req = 1; swi_req = 1; step();
        expect_state("R4 abort first", 3'd4, 0, 1);
        eret = 1; step();
        fiq_req = 1; irq_req = 1; undef_req = 1; swi_req = 1; step();
        expect_state("R4 fast over normal", 3'd1, 1, 1);
        eret = 1; step();
        irq_req = 1; undef_req = 1; swi_req = 1; step();
        expect_state("R4 normal over undefined", 3'd2, 0, 1);
        eret = 1; step();
        undef_req = 1; swi_req = 1; step();
        expect_state("R4 undefined over software", 3'd5, 0, 1);
        eret = 1; step();
        swi_req = 1; step();
        expect_state("R4 software enters supervisor", 3'd3, 0, 1);
        eret = 1; step();
        expect_state("R10 back to user", 3'd0, 0, 0);
    endtask

    task automatic t_nested();
        do_reset();
        write({1'b0, 1'b0, 3'd0});
        irq_req = 1; step();
        fiq_req = 1; step();
        expect_state("R10 nested fast", 3'd1, 1, 1);
        eret = 1; step();
        expect_state("R10 unwind to normal", 3'd2, 0, 1);
        eret = 1; step();
        expect_state("R10 unwind to user", 3'd0, 0, 0);
        eret = 1; step();
        expect_state("R11 return in user", 3'd0, 0, 0);
    endtask

    task automatic t_collide();
        do_reset();
        write({1'b0, 1'b0, 3'd6});
        eret = 1; step();
        expect_state("R11 return in system", 3'd6, 0, 0);
        undef_req = 1; wr_en = 1; wr_status = {1'b1, 1'b1, 3'd0}; step();
        expect_state("R12 exception beats write", 3'd5, 0, 1);
        abort_req = 1; eret = 1; step();
        expect_state("R12 exception beats return", 3'd4, 0, 1);
        eret = 1; step();
        expect_state("R10 restore undefined", 3'd5, 0, 1);
        eret = 1; step();
        expect_state("R10 restore system", 3'd6, 0, 0);
    endtask

    initial begin
        idle(); rst = 1;
        @(negedge clk); @(negedge clk);
        t_reset();
        t_writes();
        t_masked();
        t_entries();
        t_priority();
        t_nested();
        t_collide();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule